// File: doc/BRIEF.md
# Write-Protect and Bank-Select Command Handler

This block serves the utility commands of a serial-presence memory that shares a two-wire bus with a temperature sensor. A bit-level bus front-end hands it one event per cycle: a start (or repeated start), a received address byte, a received write-data byte, or a stop. For every byte it owns, the block returns an acknowledge or not-acknowledge decision one cycle later. It also keeps four write-protect flags, one per quarter of the memory, and the bit that selects the active half.

These commands return nothing through data bytes. All status comes back through the acknowledge bit. Setting or clearing protection needs a high-voltage qualifier from the board. A set request on a block that is already protected is refused. A protection change raises a one-cycle write-cycle request toward the nonvolatile store. A bank change is volatile and raises no such request.

Top module: `spd_guard_cmd`

## Requirements
- R1: An address byte is taken only when bits [7:4] equal the PREAMBLE parameter (default 0110); any other address byte produces no response. Bits [3:1] give the command code and bit 0 is read (1) or write (0). Write codes: 001 protect block 0, 100 protect block 1, 101 protect block 2, 000 protect block 3, 011 clear all, 110 select bank 0, 111 select bank 1. Read codes: 001, 100, 101, 000 query blocks 0 to 3, 110 query bank. Every other code is not acknowledged and does nothing.
- R2: After reset all four `wp_flags` bits are 0, `bank_sel` is 0, and `wr_req` and `resp_valid` are low.
- R3: A protect command for block x (flag `wp_flags[x]`) on an unprotected block, with `hv_ok` high at the second data byte, is acknowledged on all three bytes. At the following stop it sets `wp_flags[x]` and pulses `wr_req` for one cycle.
- R4: A protect command for a block that is already protected is not acknowledged on any byte, and it changes nothing.
- R5: A protect or clear command with `hv_ok` low at the second data byte acknowledges the first two bytes, does not acknowledge the third, and changes nothing.
- R6: A clear-all command with `hv_ok` is acknowledged on all three bytes. At stop it clears all four flags and pulses `wr_req`.
- R7: A block query is acknowledged when that block's flag is 0 and not acknowledged when it is 1.
- R8: A bank-select command acknowledges the address byte and the first data byte and does not acknowledge the second data byte. At stop it sets `bank_sel` to the selected bank, with no `wr_req`.
- R9: A bank query is acknowledged when `bank_sel` is 0 and not acknowledged when it is 1.
- R10: A start before the stop cancels a pending command. A third or later data byte is not acknowledged and cancels the command.
- R11: `resp_valid` rises exactly one cycle after each owned address or data byte event, and `resp_ack` is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start or repeated start seen |
| ev_addr | input | 1 | Address byte received on `byte_in` |
| ev_data | input | 1 | Write-data byte received on `byte_in` |
| ev_stop | input | 1 | Stop seen |
| byte_in | input | 8 | Received byte |
| hv_ok | input | 1 | High-voltage qualifier present |
| resp_valid | output | 1 | A response for the previous byte is present |
| resp_ack | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| wp_flags | output | 4 | Write-protect flag per block |
| bank_sel | output | 1 | Active bank |
| wr_req | output | 1 | One-cycle nonvolatile write request |

## Verification
The bench builds the block with the default preamble 0110. With that value, each of the sixteen code and direction combinations can be reached by a one-byte change, and a neighbouring preamble can be used to check that foreign addresses produce no response. A behavioural model predicts the response, flags, bank bit and write pulse on every cycle. The sequence covers protect, refuse, missing qualifier, over-long writes, repeated-start aborts, clear-all and both bank directions.

// File: rtl/spd_guard_cmd.sv
module spd_guard_cmd #(
  parameter logic [3:0] PREAMBLE = 4'b0110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_addr,
  input  logic       ev_data,
  input  logic       ev_stop,
  input  logic [7:0] byte_in,
  input  logic       hv_ok,
  output logic       resp_valid,
  output logic       resp_ack,
  output logic [3:0] wp_flags,
  output logic       bank_sel,
  output logic       wr_req
);
  localparam logic [2:0] K_BAD = 3'd0, K_SWP = 3'd1, K_CWP = 3'd2,
                         K_SPA = 3'd3, K_RPS = 3'd4, K_RPA = 3'd5;

  logic [2:0] kind, d_kind;
  logic [1:0] blk, d_blk, dcnt;
  logic       sel, armed, a_ack, d_ack;

  wire hit     = ev_addr && (byte_in[7:4] == PREAMBLE);
  wire rsp_now = hit || (ev_data && sel);
  wire ack_now = ev_addr ? a_ack : d_ack;

  always_comb begin
    d_kind = K_BAD;
    d_blk  = 2'd0;
    case (byte_in[3:0])
      4'b0010: begin d_kind = K_SWP; d_blk = 2'd0; end
      4'b1000: begin d_kind = K_SWP; d_blk = 2'd1; end
      4'b1010: begin d_kind = K_SWP; d_blk = 2'd2; end
      4'b0000: begin d_kind = K_SWP; d_blk = 2'd3; end
      4'b0110:       d_kind = K_CWP;
      4'b1100: begin d_kind = K_SPA; d_blk = 2'd0; end
      4'b1110: begin d_kind = K_SPA; d_blk = 2'd1; end
      4'b0011: begin d_kind = K_RPS; d_blk = 2'd0; end
      4'b1001: begin d_kind = K_RPS; d_blk = 2'd1; end
      4'b1011: begin d_kind = K_RPS; d_blk = 2'd2; end
      4'b0001: begin d_kind = K_RPS; d_blk = 2'd3; end
      4'b1101:       d_kind = K_RPA;
      default: ;
    endcase
  end

  always_comb begin
    case (d_kind)
      K_SWP, K_RPS: a_ack = !wp_flags[d_blk];
      K_CWP, K_SPA: a_ack = 1'b1;
      K_RPA:        a_ack = !bank_sel;
      default:      a_ack = 1'b0;
    endcase
    case (kind)
      K_SWP:   d_ack = !wp_flags[blk] && (dcnt == 2'd0 || (dcnt == 2'd1 && hv_ok));
      K_CWP:   d_ack = dcnt == 2'd0 || (dcnt == 2'd1 && hv_ok);
      K_SPA:   d_ack = dcnt == 2'd0;
      default: d_ack = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
      wr_req     <= 1'b0;
      wp_flags   <= 4'b0;
      bank_sel   <= 1'b0;
      sel        <= 1'b0;
      armed      <= 1'b0;
      kind       <= K_BAD;
      blk        <= 2'd0;
      dcnt       <= 2'd0;
    end else begin
      resp_valid <= rsp_now;
      resp_ack   <= rsp_now && ack_now;
      wr_req     <= 1'b0;
      if (ev_start) begin
        sel   <= 1'b0;
        armed <= 1'b0;
      end else if (ev_addr) begin
        sel   <= hit;
        kind  <= d_kind;
        blk   <= d_blk;
        dcnt  <= 2'd0;
        armed <= 1'b0;
      end else if (ev_data && sel) begin
        if (dcnt != 2'd2) dcnt <= dcnt + 2'd1;
        armed <= (dcnt == 2'd1) &&
                 (kind == K_SPA || ((kind == K_SWP || kind == K_CWP) && d_ack));
      end else if (ev_stop) begin
        if (sel && armed) begin
          case (kind)
            K_SWP: begin wp_flags[blk] <= 1'b1; wr_req <= 1'b1; end
            K_CWP: begin wp_flags <= 4'b0;      wr_req <= 1'b1; end
            K_SPA: bank_sel <= blk[0];
            default: ;
          endcase
        end
        sel   <= 1'b0;
        armed <= 1'b0;
      end
    end
  end

  a_r11_resp_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(ev_addr || ev_data));
  a_r3_wr_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> $past(ev_stop));
  a_r8_bank_moves_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel != $past(bank_sel)) |-> $past(ev_stop));
  a_r6_flags_change_with_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_flags != $past(wp_flags)) |-> wr_req);
  a_r8_no_wr_on_bank_change: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (bank_sel == $past(bank_sel)));
  a_r11_ack_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ack |-> resp_valid);
endmodule

// File: tb/spd_guard_cmd_bench.sv
module spd_guard_cmd_bench;
  localparam int EV_NONE = 0, EV_START = 1, EV_ADDR = 2, EV_DATA = 3, EV_STOP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_start = 0, ev_addr = 0, ev_data = 0, ev_stop = 0, hv_ok = 0;
  logic [7:0] byte_in = 8'h00;
  logic resp_valid, resp_ack, bank_sel, wr_req;
  logic [3:0] wp_flags;

  int checks = 0, errors = 0;
  bit done = 0;

  int  m_wp[4];
  int  m_bank, m_sel, m_kind, m_blk, m_cnt;
  bit  m_arm, e_rv, e_ra, e_wr;
  string e_req = "R2";

  always #2 clk = ~clk;

  spd_guard_cmd u_spd_guard_cmd (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_addr(ev_addr),
    .ev_data(ev_data), .ev_stop(ev_stop), .byte_in(byte_in), .hv_ok(hv_ok),
    .resp_valid(resp_valid), .resp_ack(resp_ack), .wp_flags(wp_flags),
    .bank_sel(bank_sel), .wr_req(wr_req));

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", e_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("resp_valid", int'(resp_valid), int'(e_rv));
    if (e_rv) chk("resp_ack", int'(resp_ack), int'(e_ra));
    chk("wr_req", int'(wr_req), int'(e_wr));
    chk("bank_sel", int'(bank_sel), m_bank);
    for (int i = 0; i < 4; i++) chk($sformatf("wp_flags[%0d]", i), int'(wp_flags[i]), m_wp[i]);
  endtask

  task automatic step(input int ev, input logic [7:0] b, input logic hv, input string r);
    bit a;
    @(negedge clk);
    compare();
    ev_start = (ev == EV_START); ev_addr = (ev == EV_ADDR);
    ev_data = (ev == EV_DATA); ev_stop = (ev == EV_STOP);
    byte_in = b; hv_ok = hv; e_req = r;
    e_rv = 0; e_ra = 0; e_wr = 0;
    case (ev)
      EV_START: begin m_sel = 0; m_arm = 0; end
      EV_ADDR: begin
        m_arm = 0; m_cnt = 0;
        if (b[7:4] != 4'h6) m_sel = 0;
        else begin
          m_sel = 1; m_kind = 0; m_blk = 0;
          case (b[3:0])
            4'h2: begin m_kind = 1; m_blk = 0; end
            4'h8: begin m_kind = 1; m_blk = 1; end
            4'hA: begin m_kind = 1; m_blk = 2; end
            4'h0: begin m_kind = 1; m_blk = 3; end
            4'h6: m_kind = 2;
            4'hC: begin m_kind = 3; m_blk = 0; end
            4'hE: begin m_kind = 3; m_blk = 1; end
            4'h3: begin m_kind = 4; m_blk = 0; end
            4'h9: begin m_kind = 4; m_blk = 1; end
            4'hB: begin m_kind = 4; m_blk = 2; end
            4'h1: begin m_kind = 4; m_blk = 3; end
            4'hD: m_kind = 5;
            default: m_kind = 0;
          endcase
          e_rv = 1;
          e_ra = (m_kind == 1 || m_kind == 4) ? (m_wp[m_blk] == 0) :
                 (m_kind == 2 || m_kind == 3) ? 1'b1 :
                 (m_kind == 5) ? (m_bank == 0) : 1'b0;
        end
      end
      EV_DATA: if (m_sel) begin
        e_rv = 1;
        if (m_kind == 1)      a = (m_wp[m_blk] == 0) && (m_cnt == 0 || (m_cnt == 1 && hv));
        else if (m_kind == 2) a = (m_cnt == 0) || (m_cnt == 1 && hv);
        else if (m_kind == 3) a = (m_cnt == 0);
        else                  a = 0;
        e_ra = a;
        m_arm = (m_cnt == 1) && (m_kind == 3 || ((m_kind == 1 || m_kind == 2) && a));
        m_cnt++;
      end
      EV_STOP: begin
        if (m_sel && m_arm) begin
          if (m_kind == 1) begin m_wp[m_blk] = 1; e_wr = 1; end
          if (m_kind == 2) begin for (int i = 0; i < 4; i++) m_wp[i] = 0; e_wr = 1; end
          if (m_kind == 3) m_bank = m_blk;
        end
        m_sel = 0; m_arm = 0;
      end
      default: ;
    endcase
  endtask

  task automatic txn(input logic [7:0] addr, input int ndata, input logic hv, input string r);
    step(EV_START, 8'h00, hv, r);
    step(EV_ADDR, addr, hv, r);
    for (int i = 0; i < ndata; i++) step(EV_DATA, 8'h5A + i[7:0], hv, r);
    step(EV_STOP, 8'h00, hv, r);
    step(EV_NONE, 8'h00, hv, r);
    step(EV_NONE, 8'h00, hv, r);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_wp[i] = 0;
    m_bank = 0; m_sel = 0; m_kind = 0; m_blk = 0; m_cnt = 0;
    m_arm = 0; e_rv = 0; e_ra = 0; e_wr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(EV_NONE, 8'h00, 0, "R2");
    txn(8'h63, 0, 0, "R7");
    txn(8'h62, 2, 1, "R3");
    txn(8'h63, 0, 0, "R7");
    txn(8'h62, 2, 1, "R4");
    txn(8'h68, 2, 0, "R5");
    txn(8'h6A, 3, 1, "R10");
    step(EV_START, 8'h00, 1, "R10");
    step(EV_ADDR, 8'h60, 1, "R10");
    step(EV_DATA, 8'h00, 1, "R10");
    step(EV_DATA, 8'h00, 1, "R10");
    txn(8'h61, 0, 0, "R10");
    txn(8'h60, 2, 1, "R3");
    txn(8'h69, 0, 0, "R7");
    txn(8'h61, 0, 0, "R7");
    txn(8'h66, 2, 0, "R5");
    txn(8'h66, 2, 1, "R6");
    txn(8'h61, 0, 0, "R7");
    txn(8'h6D, 0, 0, "R9");
    txn(8'h6E, 2, 0, "R8");
    txn(8'h6D, 0, 0, "R9");
    txn(8'h6C, 2, 1, "R8");
    txn(8'h6D, 0, 0, "R9");
    txn(8'h64, 2, 1, "R1");
    txn(8'h6F, 0, 0, "R1");
    txn(8'hA2, 2, 1, "R1");
    txn(8'h6A, 2, 1, "R11");
    step(EV_NONE, 8'h00, 0, "R11");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule